// File: doc/BRIEF.md
# Edge-Counting Timer Channel with Count Extension

This block counts transitions on an external pin. The pin passes through a two-stage synchronizer and an edge detector. Each qualified edge makes a one-cycle pulse that steps a 24-bit count. The count has two parts: a 16-bit main counter and an 8-bit extension field.

In up-count mode the extension field holds the most-significant bits of the count. A match fires when the full 24-bit count reaches the programmed pair of match and extension-match values. The count then returns to zero and a sticky flag is set. If the load limit is below the match value at that moment, the channel halts instead and stays halted until the load limit is written again.

In down-count mode the extension field becomes a true input divider. The main counter decrements once every (divider + 1) edges. It reloads from the load limit when it runs out.

Software uses a small write port to set the control bits, the limits and the running count. It reads the 24-bit count back on a dedicated output.

Top module: `edgecnt_timer`

## Requirements
- R1: After reset the count reads 0, the match flag and the interrupt are 0, and the channel is disabled (control register address 0 reads as all zero).
- R2: The pin is sampled through two flops. A transition held for at least 2 clocks steps the count by exactly one. The new count shows on count_o after the third rising clock edge that follows the pin change.
- R3: Control bit 1 enables counting of rising edges and control bit 2 enables counting of falling edges. With both bits set, every transition counts.
- R4: In up-count mode (control bit 3 = 0) count_o = {extension, main}. An increment from main = 0xFFFF carries into the extension.
- R5: In up-count mode, an edge that would make the count equal {extension-match (addr 4), match (addr 2)} sets the count to 0 and sets the match flag. Agreement in only the lower 16 bits does not fire.
- R6: The match flag stays set until a write to address 6 with data bit 0 = 1 clears it. If a set and a clear occur in the same cycle, the set wins. irq_o is the flag gated by control bit 4.
- R7: If a match fires while the load limit (addr 1) is below the match value, the count stays at the match value and the channel ignores edges. Only a write to the load limit releases it.
- R8: A write to address 5 loads the full 24-bit count on the next clock, and this write takes priority over a counting edge in the same cycle. A write to the load limit leaves the running count unchanged.
- R9: With control bit 0 = 0, the count is frozen and edges are ignored. When the bit is set again, counting resumes from the held value.
- R10: In down-count mode (control bit 3 = 1), each edge decrements the extension. An edge that finds the extension at 0 reloads it from the divider register (addr 3) and decrements the main counter. If the main counter is also 0, it reloads from the load limit and the match flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | 1 | Asynchronous external input to be counted |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address: 0 control, 1 load, 2 match, 3 divider, 4 extension-match, 5 count, 6 flag clear |
| reg_wdata | input | 24 | Write data |
| count_o | output | 24 | Current count {extension, main} |
| match_flag_o | output | 1 | Sticky match flag |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench targets the carry from the main counter into the extension. A design that treated the extension as a divider would show the count stalling or jumping there. It matches on a pattern where only the lower 16 bits agree; a design comparing only the main counter would fire early and clear the count. It drives the halted case: a design that reloaded anyway would keep counting after the match. It also drives the release by a load write; a design that never released would stay frozen. In down mode it checks the divider reload sequence. An off-by-one there would move the flag by a full divider period.

// File: rtl/edgecnt_timer.sv
module edgecnt_timer #(
  parameter int CW = 16,
  parameter int PW = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pin_in,
  input  logic             reg_we,
  input  logic [2:0]       reg_addr,
  input  logic [CW+PW-1:0] reg_wdata,
  output logic [CW+PW-1:0] count_o,
  output logic             match_flag_o,
  output logic             irq_o
);
  localparam int TW = CW + PW;
  localparam logic [2:0] A_CTRL = 3'd0, A_LOAD = 3'd1, A_MATCH = 3'd2,
                         A_DIV = 3'd3, A_XMATCH = 3'd4, A_COUNT = 3'd5, A_CLR = 3'd6;

  logic [2:0]    sync;
  logic          en, rise_en, fall_en, down, ie;
  logic [CW-1:0] load, match, cnt;
  logic [PW-1:0] div, xmatch, ext;
  logic          flag, halted;

  wire rise   = sync[1] & ~sync[2];
  wire fall   = ~sync[1] & sync[2];
  wire wr_cnt = reg_we && reg_addr == A_COUNT;
  wire wr_ld  = reg_we && reg_addr == A_LOAD;
  wire wr_clr = reg_we && reg_addr == A_CLR && reg_wdata[0];
  wire ev     = en && !halted && !wr_cnt && ((rise_en && rise) || (fall_en && fall));

  wire [TW-1:0] up_next = {ext, cnt} + 1'b1;
  wire up_hit   = up_next == {xmatch, match};
  wire dn_hit   = ext == '0 && cnt == '0;
  wire hit      = ev && (down ? dn_hit : up_hit);
  wire stall    = hit && !down && load < match;

  assign count_o      = {ext, cnt};
  assign match_flag_o = flag;
  assign irq_o        = flag & ie;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sync <= '0;
    else        sync <= {sync[1:0], pin_in};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {en, rise_en, fall_en, down, ie} <= '0;
      load <= '0; match <= '0; div <= '0; xmatch <= '0;
      cnt <= '0; ext <= '0; flag <= 1'b0; halted <= 1'b0;
    end else begin
      if (reg_we && reg_addr == A_CTRL)
        {ie, down, fall_en, rise_en, en} <= reg_wdata[4:0];
      if (wr_ld) load <= reg_wdata[CW-1:0];
      if (reg_we && reg_addr == A_MATCH)  match  <= reg_wdata[CW-1:0];
      if (reg_we && reg_addr == A_DIV)    div    <= reg_wdata[PW-1:0];
      if (reg_we && reg_addr == A_XMATCH) xmatch <= reg_wdata[PW-1:0];

      if (stall)      halted <= 1'b1;
      else if (wr_ld) halted <= 1'b0;

      if (hit)         flag <= 1'b1;
      else if (wr_clr) flag <= 1'b0;

      if (wr_cnt) {ext, cnt} <= reg_wdata;
      else if (ev) begin
        if (!down) begin
          if (stall)       {ext, cnt} <= {xmatch, match};
          else if (up_hit) {ext, cnt} <= '0;
          else             {ext, cnt} <= up_next;
        end else if (ext != '0) begin
          ext <= ext - 1'b1;
        end else begin
          ext <= div;
          cnt <= (cnt == '0) ? load : cnt - 1'b1;
        end
      end
    end
  end

  AST_HALT_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    halted && !wr_cnt |=> $stable(count_o)); // R7
  AST_LOAD_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ld && !ev |=> !halted); // R7
  AST_OFF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !en && !wr_cnt |=> $stable(count_o)); // R9
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    flag && !wr_clr |=> flag); // R6
  AST_UP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    ev && !down && !up_hit |=> count_o == $past(count_o) + 1'b1); // R4
  AST_SYNC_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    ev |-> $past(rise_en || fall_en)); // R3
endmodule

// File: tb/edgecnt_timer_bench.sv
module edgecnt_timer_bench;
  logic clk = 0, rst_n = 0, pin_in = 0, reg_we = 0;
  logic [2:0] reg_addr = 0;
  logic [23:0] reg_wdata = 0;
  logic [23:0] count_o;
  logic match_flag_o, irq_o;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  edgecnt_timer u_edgecnt_timer (.*);

  always #10 clk = ~clk;

  // behavioural reference
  int m_cnt, m_load, m_match, m_div, m_xm;
  bit m_en, m_r, m_f, m_dn, m_ie, m_flag, m_halt;
  bit hist[$];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_load = 0; m_match = 0; m_div = 0; m_xm = 0;
      {m_en, m_r, m_f, m_dn, m_ie, m_flag, m_halt} = '0;
      hist = '{0, 0, 0};
    end else begin
      bit s2, s3, ev, hit, stall, wv;
      int e, l, nx;
      s2 = hist[1]; s3 = hist[2];
      wv = reg_we && reg_addr == 5;
      ev = m_en && !m_halt && !wv && ((m_r && s2 && !s3) || (m_f && !s2 && s3));
      hit = 0; stall = 0;
      if (wv) m_cnt = reg_wdata;
      else if (ev) begin
        if (!m_dn) begin
          nx = (m_cnt + 1) % (1 << 24);
          if (nx == m_xm * 65536 + m_match) begin
            hit = 1;
            if (m_load < m_match) begin stall = 1; m_cnt = nx; end
            else m_cnt = 0;
          end else m_cnt = nx;
        end else begin
          e = m_cnt / 65536; l = m_cnt % 65536;
          if (e != 0) e--;
          else begin
            e = m_div;
            if (l == 0) begin l = m_load; hit = 1; end else l--;
          end
          m_cnt = e * 65536 + l;
        end
      end
      if (stall) m_halt = 1;
      else if (reg_we && reg_addr == 1) m_halt = 0;
      if (hit) m_flag = 1;
      else if (reg_we && reg_addr == 6 && reg_wdata[0]) m_flag = 0;
      if (reg_we) case (reg_addr)
        0: {m_ie, m_dn, m_f, m_r, m_en} = reg_wdata[4:0];
        1: m_load = reg_wdata[15:0];
        2: m_match = reg_wdata[15:0];
        3: m_div = reg_wdata[7:0];
        4: m_xm = reg_wdata[7:0];
        default: ;
      endcase
      hist.push_front(pin_in);
      void'(hist.pop_back());
    end
  end

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    chk("R2 model count", count_o, m_cnt);
    chk("R6 model flag", match_flag_o, m_flag);
    chk("R6 model irq", irq_o, m_flag && m_ie);
  end

  task automatic wr(int a, int d);
    @(negedge clk); reg_we = 1; reg_addr = a[2:0]; reg_wdata = d[23:0];
    @(negedge clk); reg_we = 0;
  endtask

  task automatic pulses(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); pin_in = 1; repeat (3) @(negedge clk);
      pin_in = 0; repeat (3) @(negedge clk);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 count", count_o, 0); chk("R1 flag", match_flag_o, 0); chk("R1 irq", irq_o, 0);
    pulses(1);
    chk("R1 disabled", count_o, 0);

    wr(1, 'hFFFF); wr(2, 'hFFFF); wr(4, 'hFF);
    wr(0, 'h03); pulses(3);
    chk("R2 rising", count_o, 3);
    wr(0, 'h05); pulses(2);
    chk("R3 falling", count_o, 5);
    wr(0, 'h07); pulses(2);
    chk("R3 both", count_o, 9);

    wr(0, 'h03); wr(5, 'h00FFFE);
    chk("R8 value write", count_o, 'h00FFFE);
    pulses(3);
    chk("R4 carry", count_o, 'h010001);
    wr(1, 'h1234);
    chk("R8 load keeps count", count_o, 'h010001);

    wr(0, 'h02); pulses(2);
    chk("R9 frozen", count_o, 'h010001);
    wr(0, 'h13); pulses(1);
    chk("R9 resume", count_o, 'h010002);

    wr(2, 4); wr(4, 0); wr(1, 10); wr(5, 0);
    pulses(3);
    chk("R5 below match", count_o, 3); chk("R5 no flag", match_flag_o, 0);
    pulses(1);
    chk("R5 wrap", count_o, 0); chk("R6 flag", match_flag_o, 1); chk("R6 irq", irq_o, 1);
    pulses(1);
    chk("R6 sticky", match_flag_o, 1); chk("R5 after wrap", count_o, 1);
    wr(6, 1);
    chk("R6 cleared", match_flag_o, 0); chk("R6 irq cleared", irq_o, 0);
    pulses(3);
    wr(0, 'h03);
    chk("R6 masked flag", match_flag_o, 1); chk("R6 masked irq", irq_o, 0);
    wr(6, 1);

    wr(1, 2); wr(5, 0); pulses(4);
    chk("R7 halt value", count_o, 4); chk("R7 flag", match_flag_o, 1);
    pulses(2);
    chk("R7 ignores edges", count_o, 4);
    wr(1, 10); pulses(1);
    chk("R7 released", count_o, 5);

    wr(6, 1); wr(2, 0); wr(4, 3);
    wr(5, 'h01FFFF); pulses(1);
    chk("R5 low half only", count_o, 'h020000); chk("R5 no early fire", match_flag_o, 0);
    wr(5, 'h02FFFE); pulses(1);
    chk("R4 step", count_o, 'h02FFFF);
    pulses(1);
    chk("R5 full match", count_o, 0); chk("R5 full flag", match_flag_o, 1);

    wr(6, 1); wr(3, 2); wr(1, 3); wr(0, 'h0B);
    wr(5, 'h020001); pulses(3);
    chk("R10 divided step", count_o, 'h020000); chk("R10 no flag yet", match_flag_o, 0);
    pulses(3);
    chk("R10 reload", count_o, 'h020003); chk("R10 flag", match_flag_o, 1);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule